// File: doc/BRIEF.md
# Byte-Accessed 16-bit Up/Down Timer Counter

This block holds a 16-bit timer count that a processor reaches over an 8-bit data bus. A full 16-bit read or write is atomic because the high byte always passes through one shared temporary byte. A read of the low byte captures the high byte into that temporary byte in the same cycle. A write of the low byte loads the whole count from the temporary byte and the written data.

The count moves only on qualified timer ticks. A 3-bit clock-select input picks the tick source:

- stopped;
- one of five prescaler enables;
- the falling or rising edge of an external pin, after that pin has been synchronized.

Two counting modes are available:

- **Free-running up count:** the overflow flag sets when the count wraps.
- **Triangle count:** the count rises from zero to a programmable limit, falls back to zero, and repeats. The overflow flag sets each time the count arrives at zero.

The count, its direction, the TOP and BOTTOM indications and the flag are brought out for neighbouring compare and interrupt logic.

Top module: `tmr16_bytebus`

## Requirements
- R1: While `rst` is high at a clock edge, the count, the temporary byte, `bus_rdata`, `dir_down` and `ovf_flag` all become zero.
- R2: A read is a cycle with `bus_rd`=1, `bus_wr`=0 and `bus_addr`=0 (the low byte). It places the count's low byte of that cycle on `bus_rdata` from the next cycle on. In the same edge it copies the count's high byte into the temporary byte.
- R3: A read with `bus_addr`=1 (the high byte) returns the temporary byte on `bus_rdata` in the next cycle, not the live high byte. `bus_rdata` changes only on reads, and a cycle with both `bus_wr` and `bus_rd` high is treated as a write.
- R4: A write with `bus_addr`=1 changes only the temporary byte and leaves the count untouched. A write with `bus_addr`=0 loads the count with {temporary byte, `bus_wdata`} at that edge.
- R5: A low-byte write that coincides with a tick loads the written value, and the tick has no effect on the count or the flag in that cycle.
- R6: `clk_sel`=0 gives no ticks. Values 1 to 5 use `presc_en[clk_sel-1]`. Value 6 ticks on a falling edge of `ext_pin` and value 7 on a rising edge. For the two pin settings, a pin change first sampled at clock edge E changes the count at edge E+2, once per edge.
- R7: With `mode`=0 (free-running), each tick adds one to the count. The step from 0xFFFF to 0x0000 sets `ovf_flag`.
- R8: With `mode`=1 (triangle) and `top_val`>0, ticks move the count 0,1,…,`top_val`,`top_val`-1,…,0,1,…. `dir_down` is 1 after a downward step and 0 after an upward step. A tick that brings the count to 0 sets `ovf_flag`.
- R9: With `mode`=1, a tick while the count exceeds `top_val`, or while `top_val`=0, clears the count to 0, sets `dir_down` to 0 and sets `ovf_flag`.
- R10: `at_bottom` is 1 exactly when the count is 0. `at_top` is 1 exactly when the count equals 0xFFFF in mode 0, or equals `top_val` in mode 1.
- R11: `ovf_flag` holds its value until `ovf_clr` is 1 at an edge, which clears it. If a flag-setting tick and `ovf_clr` coincide, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | Byte select: 0 low byte, 1 high byte |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Registered bus read data |
| clk_sel | input | 3 | Tick source: 0 stop, 1-5 prescaler, 6 pin fall, 7 pin rise |
| presc_en | input | 5 | One-cycle enables from the prescaler |
| ext_pin | input | 1 | Asynchronous external count pin |
| mode | input | 1 | 0 free-running up, 1 triangle between zero and top_val |
| top_val | input | 16 | Turn-around value for the triangle mode |
| ovf_clr | input | 1 | Flag-clear strobe |
| cnt_value | output | 16 | Current count |
| dir_down | output | 1 | 1 when the last triangle step was downward |
| at_top | output | 1 | Count equals the mode's maximum |
| at_bottom | output | 1 | Count equals zero |
| ovf_flag | output | 1 | Overflow flag |

## Verification
A corrupted temporary byte stays hidden until the next high-byte read. It then shows up one cycle later as a wrong `bus_rdata`, or as a wrong high byte of `cnt_value` right after a low-byte write. A wrong count or direction state shows at once on `cnt_value`, `at_top` and `at_bottom`. A direction error in the triangle mode may also show only at the next turn-around, where the count would step past `top_val` or below zero. The pin synchronizer's depth shows only as a tick that lands one edge early or late, so the bench watches the count cycle by cycle around every pin edge.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef enum logic [0:0] {
    MODE_FREE = 1'b0,
    MODE_TRI  = 1'b1
  } cnt_mode_e;

  localparam int          CS_W        = 3;
  localparam logic [2:0]  CS_STOP     = 3'd0;
  localparam logic [2:0]  CS_PIN_FALL = 3'd6;
  localparam logic [2:0]  CS_PIN_RISE = 3'd7;
endpackage

// File: rtl/tmr16_tick_sel.sv
module tmr16_tick_sel
  import tmr16_pkg::*;
#(
  parameter int N_PRESC     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CS_W-1:0]    clk_sel,
  input  logic [N_PRESC-1:0] presc_en,
  input  logic               ext_pin,
  output logic               tick
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_prev;
  logic                   pin_now;
  logic                   pin_rise;
  logic                   pin_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q   <= '0;
      pin_prev <= 1'b0;
    end else begin
      sync_q   <= {sync_q[SYNC_STAGES-2:0], ext_pin};
      pin_prev <= sync_q[SYNC_STAGES-1];
    end
  end

  assign pin_now  = sync_q[SYNC_STAGES-1];
  assign pin_rise = pin_now & ~pin_prev;
  assign pin_fall = ~pin_now & pin_prev;

  always_comb begin
    tick = 1'b0;
    if (clk_sel == CS_PIN_RISE) begin
      tick = pin_rise;
    end else if (clk_sel == CS_PIN_FALL) begin
      tick = pin_fall;
    end else begin
      for (int i = 0; i < N_PRESC; i++) begin
        if (clk_sel == CS_W'(i + 1)) tick = presc_en[i];
      end
    end
  end

  // R6: a pin edge gives a single tick, never two in a row
  p_pin_single_r6: assert property (@(posedge clk) disable iff (rst)
    (clk_sel == CS_PIN_RISE && tick) |=> (clk_sel != CS_PIN_RISE || !tick));
  p_pin_single_fall_r6: assert property (@(posedge clk) disable iff (rst)
    (clk_sel == CS_PIN_FALL && tick) |=> (clk_sel != CS_PIN_FALL || !tick));
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             mode_tri,
  input  logic [CNT_W-1:0] top_val,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_down,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] nxt_cnt;
  logic             nxt_dir;
  logic             ovf_set;
  logic             go_up;

  always_comb begin
    nxt_cnt = cnt;
    nxt_dir = dir_down;
    ovf_set = 1'b0;
    go_up   = 1'b1;
    if (ld_en) begin
      nxt_cnt = ld_val;
    end else if (tick) begin
      if (!mode_tri) begin
        nxt_cnt = cnt + ONE;
        nxt_dir = 1'b0;
        ovf_set = (cnt == '1);
      end else if (top_val == '0 || cnt > top_val) begin
        nxt_cnt = '0;
        nxt_dir = 1'b0;
        ovf_set = 1'b1;
      end else begin
        if (cnt == '0)          go_up = 1'b1;
        else if (cnt == top_val) go_up = 1'b0;
        else                    go_up = ~dir_down;
        nxt_cnt = go_up ? cnt + ONE : cnt - ONE;
        nxt_dir = ~go_up;
        ovf_set = ~go_up && (cnt == ONE);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      dir_down <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      cnt      <= nxt_cnt;
      dir_down <= nxt_dir;
      if (ovf_set)      ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

  // R5: a bus load always lands
  p_load_r5: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> cnt == $past(ld_val));
  // R7: free-running step is plus one
  p_free_step_r7: assert property (@(posedge clk) disable iff (rst)
    (!mode_tri && tick && !ld_en) |=> cnt == $past(cnt) + ONE);
  // R8: triangle count stays inside zero..top
  p_tri_range_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_tri && tick && !ld_en && top_val != '0 && cnt <= top_val)
      |=> cnt <= $past(top_val));
  // R9: out-of-range count is cleared by a tick
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_tri && tick && !ld_en && cnt > top_val) |=> (cnt == '0 && ovf));
  // R11: flag keeps its value without tick or clear
  p_ovf_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ovf_clr) |=> ovf == $past(ovf));
endmodule

// File: rtl/tmr16_bus.sv
module tmr16_bus #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [2*DATA_W-1:0] cnt,
  output logic                ld_en,
  output logic [2*DATA_W-1:0] ld_val,
  output logic [DATA_W-1:0]   bus_rdata
);
  logic [DATA_W-1:0] temp_q;
  logic              rd_lo;
  logic              rd_hi;

  assign rd_lo  = bus_rd && !bus_wr && !bus_addr;
  assign rd_hi  = bus_rd && !bus_wr && bus_addr;
  assign ld_en  = bus_wr && !bus_addr;
  assign ld_val = {temp_q, bus_wdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      temp_q    <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && bus_addr) temp_q <= bus_wdata;
      else if (rd_lo)         temp_q <= cnt[2*DATA_W-1:DATA_W];
      if (rd_lo)      bus_rdata <= cnt[DATA_W-1:0];
      else if (rd_hi) bus_rdata <= temp_q;
    end
  end

  // R2: low read returns the live low byte
  p_lo_read_r2: assert property (@(posedge clk) disable iff (rst)
    rd_lo |=> bus_rdata == $past(cnt[DATA_W-1:0]));
  // R3: temporary byte moves only on a high write or a low read
  p_temp_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!bus_wr && !rd_lo) |=> $stable(temp_q));
  // R3: read data holds without a read
  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && !bus_wr) |=> $stable(bus_rdata));
endmodule

// File: rtl/tmr16_bytebus.sv
module tmr16_bytebus
  import tmr16_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int N_PRESC     = 5,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = 2 * DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [CS_W-1:0]    clk_sel,
  input  logic [N_PRESC-1:0] presc_en,
  input  logic               ext_pin,
  input  logic               mode,
  input  logic [CNT_W-1:0]   top_val,
  input  logic               ovf_clr,
  output logic [CNT_W-1:0]   cnt_value,
  output logic               dir_down,
  output logic               at_top,
  output logic               at_bottom,
  output logic               ovf_flag
);
  cnt_mode_e        mode_e;
  logic             tick;
  logic             ld_en;
  logic [CNT_W-1:0] ld_val;

  assign mode_e = cnt_mode_e'(mode);

  tmr16_tick_sel #(.N_PRESC(N_PRESC), .SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .presc_en(presc_en),
    .ext_pin(ext_pin), .tick(tick)
  );

  tmr16_bus #(.DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .cnt(cnt_value),
    .ld_en(ld_en), .ld_val(ld_val), .bus_rdata(bus_rdata)
  );

  tmr16_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .ld_en(ld_en), .ld_val(ld_val),
    .mode_tri(mode_e == MODE_TRI), .top_val(top_val), .ovf_clr(ovf_clr),
    .cnt(cnt_value), .dir_down(dir_down), .ovf(ovf_flag)
  );

  assign at_bottom = (cnt_value == '0);
  assign at_top    = (mode_e == MODE_TRI) ? (cnt_value == top_val) : (&cnt_value);

  // R6: a stopped timer only changes through the bus
  p_stop_r6: assert property (@(posedge clk) disable iff (rst)
    (clk_sel == CS_STOP && !ld_en) |=> $stable(cnt_value));
  // R4: high-byte write never moves a stopped count
  p_hi_write_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr && clk_sel == CS_STOP) |=> $stable(cnt_value));
endmodule

// File: tb/test_tmr16_bytebus.sv
module test_tmr16_bytebus;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [2:0]  clk_sel = 3'd0;
  logic [4:0]  presc_en = 5'd0;
  logic        ext_pin = 1'b0;
  logic        mode = 1'b0;
  logic [15:0] top_val = 16'd0;
  logic        ovf_clr = 1'b0;
  logic [15:0] cnt_value;
  logic        dir_down, at_top, at_bottom, ovf_flag;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_cnt = 0;
  logic        m_dir = 0, m_ovf = 0;
  logic [7:0]  m_temp = 0, m_rdata = 0;
  logic        m_s0 = 0, m_s1 = 0, m_prev = 0;

  always #(CLK_P/2) clk = ~clk;

  tmr16_bytebus i_tmr16_bytebus (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .clk_sel(clk_sel), .presc_en(presc_en), .ext_pin(ext_pin),
    .mode(mode), .top_val(top_val), .ovf_clr(ovf_clr),
    .cnt_value(cnt_value), .dir_down(dir_down), .at_top(at_top),
    .at_bottom(at_bottom), .ovf_flag(ovf_flag)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(mode ? "R8" : "R7", cnt_value, m_cnt);
    chk("R8", dir_down, m_dir);
    chk("R11", ovf_flag, m_ovf);
    chk("R10", at_bottom, m_cnt == 0);
    chk("R10", at_top, mode ? (m_cnt == top_val) : (m_cnt == 16'hFFFF));
    chk("R2", bus_rdata, m_rdata);
  endtask

  // expected next state from the requirements, then one clock
  task automatic step();
    logic        tk, set, up;
    logic [15:0] n_cnt;
    logic        n_dir;
    logic [7:0]  n_temp, n_rd;
    tk = 0; set = 0; up = 1;
    case (clk_sel)
      3'd0: tk = 0;
      3'd6: tk = !m_s1 && m_prev;
      3'd7: tk = m_s1 && !m_prev;
      default: tk = presc_en[clk_sel - 3'd1];
    endcase
    n_cnt = m_cnt; n_dir = m_dir; n_temp = m_temp; n_rd = m_rdata;
    if (bus_wr && !bus_addr) n_cnt = {m_temp, bus_wdata};
    else if (tk) begin
      if (!mode) begin
        n_cnt = m_cnt + 16'd1; n_dir = 0; set = (m_cnt == 16'hFFFF);
      end else if (top_val == 0 || m_cnt > top_val) begin
        n_cnt = 0; n_dir = 0; set = 1;
      end else begin
        up = (m_cnt == 0) ? 1'b1 : (m_cnt == top_val) ? 1'b0 : !m_dir;
        n_cnt = up ? m_cnt + 16'd1 : m_cnt - 16'd1;
        n_dir = !up;
        set = (n_cnt == 0);
      end
    end
    if (bus_wr && bus_addr) n_temp = bus_wdata;
    else if (!bus_wr && bus_rd && !bus_addr) n_temp = m_cnt[15:8];
    if (!bus_wr && bus_rd) n_rd = bus_addr ? m_temp : m_cnt[7:0];
    @(posedge clk);
    if (rst) begin
      m_cnt = 0; m_dir = 0; m_ovf = 0; m_temp = 0; m_rdata = 0;
      m_s0 = 0; m_s1 = 0; m_prev = 0;
    end else begin
      m_prev = m_s1; m_s1 = m_s0; m_s0 = ext_pin;
      m_cnt = n_cnt; m_dir = n_dir; m_temp = n_temp; m_rdata = n_rd;
      if (set) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
    end
    @(negedge clk);
    check_all();
  endtask

  task automatic bus_write(logic a, logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 0;
  endtask

  task automatic bus_read(logic a);
    bus_rd = 1; bus_addr = a;
    step();
    bus_rd = 0;
  endtask

  task automatic load(logic [15:0] v);
    bus_write(1, v[15:8]);
    bus_write(0, v[7:0]);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    rst = 1;
    for (int i = 0; i < 3; i++) step();
    rst = 0;
    step();
    chk("R1", cnt_value, 0); chk("R1", ovf_flag, 0);
    chk("R1", bus_rdata, 0); chk("R1", dir_down, 0);

    // R4: high write alone leaves the count, low write loads all 16 bits
    bus_write(1, 8'h12);
    chk("R4", cnt_value, 16'h0000);
    bus_write(0, 8'hFE);
    chk("R4", cnt_value, 16'h12FE);
    for (int i = 0; i < 5; i++) step();
    chk("R6", cnt_value, 16'h12FE);

    // R2 then R3: read low, count across a byte boundary, read high
    bus_read(0);
    chk("R2", bus_rdata, 8'hFE);
    clk_sel = 3'd1; presc_en = 5'b00001;
    for (int i = 0; i < 3; i++) step();
    clk_sel = 3'd0;
    chk("R6", cnt_value, 16'h1301);
    bus_read(1);
    chk("R3", bus_rdata, 8'h12);

    // R5: write beats a coincident tick
    clk_sel = 3'd3; presc_en = 5'b00100;
    bus_write(1, 8'h00);
    bus_write(0, 8'h05);
    chk("R5", cnt_value, 16'h0005);
    presc_en = 5'b00000;
    step();
    chk("R6", cnt_value, 16'h0005);

    // R7: wrap sets the flag, R11 clear and set-wins
    clk_sel = 3'd0; load(16'hFFFE);
    clk_sel = 3'd5; presc_en = 5'b10000;
    step(); chk("R10", at_top, 1);
    step(); chk("R7", ovf_flag, 1); chk("R7", cnt_value, 0);
    clk_sel = 3'd0; ovf_clr = 1; step(); ovf_clr = 0;
    chk("R11", ovf_flag, 0);
    load(16'hFFFF);
    clk_sel = 3'd5; ovf_clr = 1; step(); ovf_clr = 0; clk_sel = 3'd0;
    chk("R11", ovf_flag, 1);
    ovf_clr = 1; step(); ovf_clr = 0;

    // R6: pin edges, latency two edges
    load(16'h0100);
    clk_sel = 3'd7; presc_en = 5'b11111;
    ext_pin = 1; step(); step();
    chk("R6", cnt_value, 16'h0100);
    step(); chk("R6", cnt_value, 16'h0101);
    for (int i = 0; i < 4; i++) step();
    chk("R6", cnt_value, 16'h0101);
    clk_sel = 3'd6; ext_pin = 0;
    for (int i = 0; i < 4; i++) step();
    chk("R6", cnt_value, 16'h0102);
    presc_en = 0;

    // R8: triangle with top 3
    clk_sel = 3'd0; load(16'h0000);
    mode = 1; top_val = 16'd3; clk_sel = 3'd1; presc_en = 5'b00001;
    for (int i = 0; i < 3; i++) step();
    chk("R8", cnt_value, 3); chk("R10", at_top, 1);
    step(); chk("R8", cnt_value, 2); chk("R8", dir_down, 1);
    step(); step();
    chk("R8", cnt_value, 0); chk("R8", ovf_flag, 1);
    step(); chk("R8", cnt_value, 1); chk("R8", dir_down, 0);

    // R9: above top clears
    clk_sel = 3'd0; load(16'd10);
    clk_sel = 3'd1; ovf_clr = 1; step(); ovf_clr = 0;
    chk("R9", cnt_value, 0); chk("R9", ovf_flag, 1);
    top_val = 0; step(); chk("R9", cnt_value, 0);
    clk_sel = 3'd0; ovf_clr = 1; step(); ovf_clr = 0;

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      bus_wr = (r < 6); bus_rd = (r >= 6 && r < 14);
      bus_addr = $urandom_range(0, 1);
      bus_wdata = 8'($urandom_range(0, 255));
      if (bus_wr && !bus_addr && $urandom_range(0, 3) != 0) bus_wdata = 8'($urandom_range(0, 20));
      presc_en = 5'($urandom_range(0, 31));
      if ($urandom_range(0, 5) == 0) ext_pin = ~ext_pin;
      if ($urandom_range(0, 50) == 0) clk_sel = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 200) == 0) mode = ~mode;
      if ($urandom_range(0, 150) == 0) top_val = 16'($urandom_range(0, 15));
      ovf_clr = ($urandom_range(0, 9) == 0);
      step();
    end
    bus_wr = 0; bus_rd = 0; ovf_clr = 0;
    step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule